// File: doc/BRIEF.md
# Framer Interrupt Status Register

This block gathers three single-cycle event pulses from a receive framer into sticky status bits of one 8-bit register. The three events are a change in the signaling bits, a change of frame alignment, and a change in the out-of-frame condition. A status bit is set only when its event arrives while the matching enable input is high. Once set, the bit stays set until software clears it.

Software can clear the bits in one of two ways, chosen by a mode input. In clear-on-read mode, any read of the register clears all status bits. In write-one-to-clear mode, a write clears exactly the bits written as one, and reads have no side effect. When an event arrives in the same cycle as its clear, the event wins, so no event is lost. An active-high interrupt output is the OR of the status bits, each masked by its enable. The detectors that produce the event pulses are outside this block.

Top module: `frm_irq_status`

## Requirements
- R1: After a synchronous active-low reset, every status bit is 0, `rd_data` reads 8'h00 and `irq` is 0.
- R2: `rd_data` bit 5 holds the signaling-change status, bit 4 the alignment-change status and bit 3 the out-of-frame-change status. Bits 7, 6 and 2 to 0 always read 0.
- R3: An event pulse sampled at a clock edge while its enable is 1 sets its status bit, and the bit is visible on `rd_data` after that edge.
- R4: An event pulse sampled while its enable is 0 leaves its status bit unchanged.
- R5: A set status bit stays set through any number of idle cycles until it is cleared.
- R6: With `clr_mode`=0 (clear-on-read), a cycle with `rd_en`=1 clears every status bit at the edge that ends the read cycle, and writes have no effect on the status.
- R7: With `clr_mode`=1 (write-one-to-clear), a cycle with `wr_en`=1 clears each status bit whose `wr_data` bit is 1 and keeps the bits written as 0. A read has no effect on the status.
- R8: An enabled event in the same cycle as a clear of its bit (a clearing read or a one-write) leaves that bit set.
- R9: `irq` is 1 exactly when some status bit is 1 and its enable is currently 1. It follows a change of an enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_sig_chg | input | 1 | Pulse: signaling bits changed |
| evt_align_chg | input | 1 | Pulse: frame alignment changed |
| evt_oof_chg | input | 1 | Pulse: out-of-frame condition changed |
| en_sig | input | 1 | Enable for the signaling-change status |
| en_align | input | 1 | Enable for the alignment-change status |
| en_oof | input | 1 | Enable for the out-of-frame-change status |
| clr_mode | input | 1 | 0 = clear-on-read, 1 = write-one-to-clear |
| rd_en | input | 1 | Register read strobe for this cycle |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register image |
| irq | output | 1 | Interrupt, active high |

## Verification
A status flop that sets wrongly, sets without its enable, or fails to clear appears on `rd_data` at the first sample after the clock edge where the fault happens. The bench compares every cycle against a behavioural model, so a wrong bit is reported within one cycle. A wrong masking term shows on `irq` in the same cycle as the enable change that exposes it. A mis-wired clear path, such as a read that clears in write-one-to-clear mode or an event lost to a simultaneous clear, becomes a mismatch one cycle after the access.

// File: rtl/fisr_pkg.sv
// Package: shared constants and types for the framer interrupt status register.
// Assumes one 8-bit register with the event field placed at EVT_LSB.
package fisr_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_EVT = 3;
    localparam int EVT_LSB = 3;   // oof at LSB, then align, then signaling

    typedef enum logic {
        CLR_ON_READ = 1'b0,
        CLR_W1C     = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/fisr_clear_ctl.sv
// Module: works out the per-bit clear request from the access strobes and the clear mode.
// Assumes rd_en and wr_en are single-cycle strobes. wr_bits is the event field of wr_data.
module fisr_clear_ctl
    import fisr_pkg::*;
#(
    parameter int N_EVT = NUM_EVT
) (
    input  logic             clr_mode,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [N_EVT-1:0] wr_bits,
    output logic [N_EVT-1:0] clr_vec
);
    // Pick the clear source for each bit based on the mode.
    always_comb begin
        for (int i = 0; i < N_EVT; i++) begin
            if (clr_mode_e'(clr_mode) == CLR_ON_READ)
                clr_vec[i] = rd_en;
            else
                clr_vec[i] = wr_en & wr_bits[i];
        end
    end

    // R7: in write-one-to-clear mode, a cycle with no write requests no clear.
    always_comb begin
        a_r7_read_no_clear: assert (!(clr_mode && !wr_en) || (clr_vec == '0));
    end
    // R6: in clear-on-read mode, a write without a read requests no clear.
    always_comb begin
        a_r6_write_ignored: assert (!(!clr_mode && !rd_en) || (clr_vec == '0));
    end
endmodule

// File: rtl/fisr_sticky_bit.sv
// Module: one sticky status flop. Set has priority over clear.
// Assumes set_i is already gated by the event's enable. Synchronous active-low reset.
module fisr_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic st_o
);
    // Hold the flag; set wins over clear, so no event is lost.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_o <= 1'b0;
        else if (set_i)
            st_o <= 1'b1;
        else if (clr_i)
            st_o <= 1'b0;
    end

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_o);
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !st_o);
    a_r5_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> (st_o == $past(st_o)));
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !st_o) |=> !st_o);
endmodule

// File: rtl/frm_irq_status.sv
// Module: framer interrupt status register. It latches enabled event pulses into sticky
// bits, clears them by read or by write-one, and drives an enable-masked interrupt.
// Assumes event pulses are synchronous to clk. Synchronous active-low reset.
module frm_irq_status
    import fisr_pkg::*;
#(
    parameter int DATA_W  = REG_W,
    parameter int FLD_LSB = EVT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_sig_chg,
    input  logic              evt_align_chg,
    input  logic              evt_oof_chg,
    input  logic              en_sig,
    input  logic              en_align,
    input  logic              en_oof,
    input  logic              clr_mode,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int N_EVT  = NUM_EVT;
    localparam int FLD_HI = FLD_LSB + N_EVT - 1;

    logic [N_EVT-1:0] evt_vec;
    logic [N_EVT-1:0] en_vec;
    logic [N_EVT-1:0] clr_vec;
    logic [N_EVT-1:0] st_vec;
    logic             unused_wr_bits;

    assign evt_vec = {evt_sig_chg, evt_align_chg, evt_oof_chg};
    assign en_vec  = {en_sig, en_align, en_oof};
    assign unused_wr_bits = ^{wr_data[DATA_W-1:FLD_HI+1], wr_data[FLD_LSB-1:0]};

    fisr_clear_ctl #(.N_EVT(N_EVT)) u_clr (
        .clr_mode (clr_mode),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wr_bits  (wr_data[FLD_HI:FLD_LSB]),
        .clr_vec  (clr_vec)
    );

    // One sticky flop per event, with the set gated by its enable.
    for (genvar g = 0; g < N_EVT; g++) begin : g_bit
        fisr_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_vec[g] & en_vec[g]),
            .clr_i (clr_vec[g]),
            .st_o  (st_vec[g])
        );
    end

    // Place the status field in the register image; the other bits read as zero.
    always_comb begin
        rd_data = '0;
        rd_data[FLD_HI:FLD_LSB] = st_vec;
    end

    // Drive the interrupt from the status bits masked by their enables.
    assign irq = |(st_vec & en_vec);

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !irq);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));
endmodule

// File: tb/test_frm_irq_status.sv
module test_frm_irq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] evt = '0;      // [2]=sig, [1]=align, [0]=oof
    logic [2:0] en  = '0;
    logic       clr_mode = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit m_st [3];

    always #2 clk = ~clk;   // 250 MHz

    frm_irq_status i_frm_irq_status (
        .clk(clk), .rst_n(rst_n),
        .evt_sig_chg(evt[2]), .evt_align_chg(evt[1]), .evt_oof_chg(evt[0]),
        .en_sig(en[2]), .en_align(en[1]), .en_oof(en[0]),
        .clr_mode(clr_mode), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Behavioural model of the requirements.
    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            bit hit, wipe;
            hit  = evt[i] && en[i];
            wipe = clr_mode ? (wr_en && wr_data[3+i]) : rd_en;
            if (!rst_n)    m_st[i] <= 1'b0;
            else if (hit)  m_st[i] <= 1'b1;
            else if (wipe) m_st[i] <= 1'b0;
        end
    end

    function automatic logic [7:0] model_img();
        logic [7:0] v = '0;
        for (int i = 0; i < 3; i++) v[3+i] = m_st[i];
        return v;
    endfunction

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int i = 0; i < 3; i++) r |= m_st[i] && en[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Compare against the model every cycle after reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 image", rd_data, model_img());
            check("R9 irq", {7'b0, irq}, {7'b0, model_irq()});
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Drive one cycle of stimulus, then return the pulses to idle.
    task automatic apply(input logic [2:0] e, input logic r, input logic w, input logic [7:0] d);
        evt = e; rd_en = r; wr_en = w; wr_data = d;
        @(negedge clk);
        evt = '0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        en = 3'b111; clr_mode = 1'b0;

        apply(3'b100, 0, 0, 0); check("R3 sig at bit5", rd_data, 8'h20);
        check("R9 irq high", {7'b0, irq}, 8'h01);
        apply(3'b010, 0, 0, 0); check("R2 align at bit4", rd_data, 8'h30);
        apply(3'b001, 0, 0, 0); check("R2 oof at bit3", rd_data, 8'h38);
        repeat (5) apply(3'b000, 0, 0, 0);
        check("R5 sticky", rd_data, 8'h38);
        apply(3'b000, 0, 1, 8'hFF); check("R6 write ignored", rd_data, 8'h38);
        apply(3'b000, 1, 0, 0); check("R6 read clears", rd_data, 8'h00);

        en = 3'b011;
        apply(3'b100, 0, 0, 0); check("R4 disabled event", rd_data, 8'h00);
        en = 3'b111;

        apply(3'b111, 0, 0, 0);
        clr_mode = 1'b1;
        apply(3'b000, 1, 0, 0); check("R7 read no effect", rd_data, 8'h38);
        apply(3'b000, 0, 1, 8'h10); check("R7 w1c align", rd_data, 8'h28);
        apply(3'b000, 0, 1, 8'hC7); check("R7 zero/reserved bits keep", rd_data, 8'h28);
        apply(3'b100, 0, 1, 8'h20); check("R8 event beats w1c", rd_data, 8'h28);
        clr_mode = 1'b0;
        apply(3'b010, 1, 0, 0); check("R8 event beats read", rd_data, 8'h10);

        en = 3'b000; #1;
        check("R9 masked irq", {7'b0, irq}, 8'h00);
        check("R9 status kept", rd_data, 8'h10);
        en = 3'b010; #1;
        check("R9 unmasked irq", {7'b0, irq}, 8'h01);
        @(negedge clk);

        // Random traffic compared against the model every cycle.
        for (int n = 0; n < 3000; n++) begin
            en       = 3'($urandom);
            clr_mode = 1'($urandom);
            apply(3'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0, 8'($urandom));
        end

        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", rd_data, 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule